// File: doc/BRIEF.md
# Block Cipher Chaining Controller

This block wraps an external 128-bit block cipher core and turns it into an ECB or CBC engine. Input blocks arrive on a valid/ready stream. Each block may have its bytes reordered, and may be XOR-ed with a chaining vector before it goes to the core. The core's answer may be XOR-ed with the vector afterwards. The result then leaves on a second valid/ready stream. Only one block is in flight between the controller and the core at any time.

Three independent fields select the chaining behaviour:

- **XOR placement**: none, before the cipher, or after the cipher.
- **Vector source**: what feeds the chaining register after each block.
- **Core direction**: forward or inverse cipher.

With these fields, one datapath covers CBC encryption, CBC decryption and ECB.

A job begins with a start pulse. The pulse latches the configuration and copies the initial vector into the chaining register. The register keeps its last value after the final block, so the host can read it back to continue a chain later.

Top module: `blk_chain_ctrl`

## Requirements
- R1: After reset the block is idle. `in_ready` is 1, `out_valid` and `core_req_valid` are 0, `chain_out` is zero, and the latched configuration is XOR bypass, no swap, inverse core, generator off.
- R2: A `job_start` pulse while idle latches all `cfg_*` inputs and loads `chain_out` with `iv_in` on the next cycle. Changes on `cfg_*` between start pulses have no effect on the job.
- R3: An XOR placement of 0 or 1 bypasses both XORs. The output block is the core result for the (possibly swapped) input.
- R4: An XOR placement of 2 sends the input block XOR the chaining register to the core.
- R5: An XOR placement of 3 sends the input block unchanged to the core and emits the core result XOR the chaining register.
- R6: With XOR placement 2 or 3 and vector source 2, the chaining register takes the core result of each block. This is the CBC encryption setting.
- R7: With XOR placement 2 or 3 and vector source 3, the chaining register takes the (swapped) input block of each block. This is the CBC decryption setting.
- R8: With XOR placement 0 or 1, or with vector source 0 or 1, the chaining register is never changed by blocks.
- R9: `core_req_fwd` carries the latched core select: 1 requests the forward cipher, 0 the inverse cipher.
- R10: When the latched swap bit is 1, the block reverses the byte order inside every 32-bit word, on both the input and the output. The chaining register and the core both work on the swapped form.
- R11: A job started with `cfg_rng_en` = 1 accepts no input blocks (`in_ready` stays 0) until the next `job_start`.
- R12: At most one block is in flight, and `in_ready` is 0 from acceptance until the output is taken. `core_req_valid` and `core_req_data` hold until `core_req_ready`. `out_valid` and `out_data` hold until `out_ready`.
- R13: `chain_out` shows the chaining register at all times and keeps its final value after the last block of a job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_xor_pos | input | 2 | XOR placement: 0/1 none, 2 before core, 3 after core |
| cfg_vec_src | input | 2 | Chaining source: 2 core result, 3 input block, 0/1 hold |
| cfg_fwd | input | 1 | 1 forward cipher, 0 inverse cipher |
| cfg_swap | input | 1 | Byte reverse each 32-bit word of the stream |
| cfg_rng_en | input | 1 | Generator enable; must be 0 for block jobs |
| iv_in | input | 128 | Initial vector loaded at job start |
| job_start | input | 1 | Start pulse: latch config, load vector |
| in_valid | input | 1 | Input block valid |
| in_ready | output | 1 | Input block accepted |
| in_data | input | 128 | Input block |
| core_req_valid | output | 1 | Request to cipher core valid |
| core_req_ready | input | 1 | Cipher core accepts request |
| core_req_data | output | 128 | Block sent to the core |
| core_req_fwd | output | 1 | Direction for the core |
| core_rsp_valid | input | 1 | Core result valid |
| core_rsp_data | input | 128 | Core result |
| out_valid | output | 1 | Output block valid |
| out_ready | input | 1 | Output block taken |
| out_data | output | 128 | Output block |
| chain_out | output | 128 | Current chaining register |

## Verification
A corrupted chaining register shows up in the very next CBC output block. It then keeps spreading, because each following block folds the bad vector into its XOR. The bench compares every output-valid cycle against a behavioural model, so such an error is reported within one block of its cause. A wrong update choice between core result and input block stays invisible in ECB. For that reason the vector is read back at `chain_out` after each job, and a CBC encryption is decrypted again to recover the plaintext. Byte-order and direction faults break the first output block of the job in which they are enabled.

// File: rtl/blk_chain_pkg.sv
package blk_chain_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_OUT  = 2'd3
  } chain_state_e;

  localparam logic [1:0] XOR_BEFORE = 2'd2;
  localparam logic [1:0] XOR_AFTER  = 2'd3;
  localparam logic [1:0] VEC_CORE   = 2'd2;
  localparam logic [1:0] VEC_INPUT  = 2'd3;

  typedef struct packed {
    logic [1:0] xor_pos;
    logic [1:0] vec_src;
    logic       fwd;
    logic       swap;
    logic       rng;
  } chain_cfg_t;

endpackage

// File: rtl/blk_word_swap.sv
module blk_word_swap #(
  parameter int BLK_W  = 128,
  parameter int WORD_W = 32
) (
  input  logic             en,
  input  logic [BLK_W-1:0] din,
  output logic [BLK_W-1:0] dout
);
  localparam int NWORD = BLK_W / WORD_W;
  localparam int NBYTE = WORD_W / 8;

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    for (genvar b = 0; b < NBYTE; b++) begin : g_byte
      assign dout[w*WORD_W + b*8 +: 8] = en ? din[w*WORD_W + (NBYTE-1-b)*8 +: 8]
                                            : din[w*WORD_W + b*8 +: 8];
    end
  end
endmodule

// File: rtl/blk_chain_vec.sv
module blk_chain_vec #(
  parameter int BLK_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [BLK_W-1:0] load_val,
  input  logic             upd,
  input  logic [BLK_W-1:0] upd_val,
  output logic [BLK_W-1:0] vec
);
  always_ff @(posedge clk) begin
    if (rst)       vec <= '0;
    else if (load) vec <= load_val;
    else if (upd)  vec <= upd_val;
  end
endmodule

// File: rtl/blk_chain_ctrl.sv
module blk_chain_ctrl
  import blk_chain_pkg::*;
#(
  parameter int BLK_W  = 128,
  parameter int WORD_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_xor_pos,
  input  logic [1:0]       cfg_vec_src,
  input  logic             cfg_fwd,
  input  logic             cfg_swap,
  input  logic             cfg_rng_en,
  input  logic [BLK_W-1:0] iv_in,
  input  logic             job_start,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BLK_W-1:0] in_data,
  output logic             core_req_valid,
  input  logic             core_req_ready,
  output logic [BLK_W-1:0] core_req_data,
  output logic             core_req_fwd,
  input  logic             core_rsp_valid,
  input  logic [BLK_W-1:0] core_rsp_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [BLK_W-1:0] out_data,
  output logic [BLK_W-1:0] chain_out
);
  chain_state_e     st_q;
  chain_cfg_t       cfg_q;
  logic [BLK_W-1:0] in_sw, raw_q, req_q, out_q, res_pre, res_sw;
  logic             start_ok, in_fire, rsp_fire, xor_on, vec_upd;
  logic [BLK_W-1:0] vec_val;
  logic             is_idle;

  assign is_idle  = (st_q == ST_IDLE);
  assign start_ok = job_start && is_idle;
  assign in_ready = is_idle && !job_start && !cfg_q.rng;
  assign in_fire  = in_valid && in_ready;
  assign rsp_fire = (st_q == ST_WAIT) && core_rsp_valid;
  assign xor_on   = cfg_q.xor_pos[1];

  blk_word_swap #(.BLK_W(BLK_W), .WORD_W(WORD_W)) u_swap_in (
    .en(cfg_q.swap), .din(in_data), .dout(in_sw));

  assign res_pre = (cfg_q.xor_pos == XOR_AFTER) ? (core_rsp_data ^ chain_out) : core_rsp_data;

  blk_word_swap #(.BLK_W(BLK_W), .WORD_W(WORD_W)) u_swap_out (
    .en(cfg_q.swap), .din(res_pre), .dout(res_sw));

  assign vec_upd = rsp_fire && xor_on && cfg_q.vec_src[1];
  assign vec_val = (cfg_q.vec_src == VEC_INPUT) ? raw_q : core_rsp_data;

  blk_chain_vec #(.BLK_W(BLK_W)) u_vec (
    .clk(clk), .rst(rst),
    .load(start_ok), .load_val(iv_in),
    .upd(vec_upd), .upd_val(vec_val),
    .vec(chain_out));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cfg_q <= '0;
      raw_q <= '0;
      req_q <= '0;
      out_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start_ok) begin
            cfg_q <= '{xor_pos: cfg_xor_pos, vec_src: cfg_vec_src, fwd: cfg_fwd,
                       swap: cfg_swap, rng: cfg_rng_en};
          end else if (in_fire) begin
            raw_q <= in_sw;
            req_q <= (cfg_q.xor_pos == XOR_BEFORE) ? (in_sw ^ chain_out) : in_sw;
            st_q  <= ST_REQ;
          end
        end
        ST_REQ:  if (core_req_ready) st_q <= ST_WAIT;
        ST_WAIT: if (rsp_fire) begin
          out_q <= res_sw;
          st_q  <= ST_OUT;
        end
        ST_OUT:  if (out_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign core_req_valid = (st_q == ST_REQ);
  assign core_req_data  = req_q;
  assign core_req_fwd   = cfg_q.fwd;
  assign out_valid      = (st_q == ST_OUT);
  assign out_data       = out_q;
endmodule

// File: rtl/blk_chain_chk.sv
module blk_chain_chk #(
  parameter int BLK_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             job_start,
  input logic             is_idle,
  input logic             cfg_rng_en,
  input logic [BLK_W-1:0] iv_in,
  input logic             in_valid,
  input logic             in_ready,
  input logic             core_req_valid,
  input logic             core_req_ready,
  input logic [BLK_W-1:0] core_req_data,
  input logic             core_rsp_valid,
  input logic             out_valid,
  input logic             out_ready,
  input logic [BLK_W-1:0] out_data,
  input logic [BLK_W-1:0] chain_out
);
  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    job_start && is_idle |=> chain_out == $past(iv_in));
  // R11
  rng_block_chk: assert property (@(posedge clk) disable iff (rst)
    job_start && is_idle && cfg_rng_en |=> !in_ready);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    core_req_valid && !core_req_ready |=> core_req_valid && $stable(core_req_data));
  // R12
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R12
  in_to_req_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> core_req_valid && !in_ready);
  // R12
  single_flight_chk: assert property (@(posedge clk) disable iff (rst)
    !(core_req_valid && out_valid) && !(in_ready && (core_req_valid || out_valid)));
  // R13
  vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !job_start && !core_rsp_valid |=> $stable(chain_out));
endmodule

bind blk_chain_ctrl blk_chain_chk #(.BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst(rst), .job_start(job_start), .is_idle(is_idle),
  .cfg_rng_en(cfg_rng_en), .iv_in(iv_in), .in_valid(in_valid), .in_ready(in_ready),
  .core_req_valid(core_req_valid), .core_req_ready(core_req_ready),
  .core_req_data(core_req_data), .core_rsp_valid(core_rsp_valid),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .chain_out(chain_out));

// File: tb/blk_chain_ctrl_bench.sv
`timescale 1ns/1ps
module blk_chain_ctrl_bench;
  localparam int BW = 128;
  localparam logic [BW-1:0] KEY = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;

  logic clk = 0, rst = 1;
  logic [1:0] cfg_xor_pos = 0, cfg_vec_src = 0;
  logic cfg_fwd = 0, cfg_swap = 0, cfg_rng_en = 0, job_start = 0;
  logic [BW-1:0] iv_in = '0, in_data = '0;
  logic in_valid = 0, in_ready;
  logic core_req_valid, core_req_ready, core_req_fwd, core_rsp_valid;
  logic [BW-1:0] core_req_data, core_rsp_data, out_data, chain_out;
  logic out_valid, out_ready;

  blk_chain_ctrl u_blk_chain_ctrl (
    .clk(clk), .rst(rst), .cfg_xor_pos(cfg_xor_pos), .cfg_vec_src(cfg_vec_src),
    .cfg_fwd(cfg_fwd), .cfg_swap(cfg_swap), .cfg_rng_en(cfg_rng_en), .iv_in(iv_in),
    .job_start(job_start), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .core_req_valid(core_req_valid), .core_req_ready(core_req_ready),
    .core_req_data(core_req_data), .core_req_fwd(core_req_fwd),
    .core_rsp_valid(core_rsp_valid), .core_rsp_data(core_rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .chain_out(chain_out));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit stall_en = 0;
  string cur_tag = "R3";

  // bench model state
  logic [1:0] m_xp = 0, m_vs = 0;
  bit m_fwd = 0, m_swap = 0;
  logic [BW-1:0] m_chain = '0;
  logic [BW-1:0] exp_q[$];
  logic [BW-1:0] ct_log[$];

  function automatic logic [BW-1:0] bswap(input logic [BW-1:0] x);
    logic [BW-1:0] r;
    for (int i = 0; i < BW/8; i++) r[i*8 +: 8] = x[((i/4)*4 + 3 - (i%4))*8 +: 8];
    return r;
  endfunction
  function automatic logic [BW-1:0] fenc(input logic [BW-1:0] x);
    return {x[BW-9:0], x[BW-1:BW-8]} ^ KEY;
  endfunction
  function automatic logic [BW-1:0] fdec(input logic [BW-1:0] y);
    logic [BW-1:0] t;
    t = y ^ KEY;
    return {t[7:0], t[BW-1:8]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    out_ready <= !(stall_en && (cyc % 3 == 1));
  end

  // cipher core model: one block, variable latency
  logic [BW-1:0] cm_res;
  int cm_dly, cm_lat;
  bit cm_busy;
  always @(posedge clk) begin
    if (rst) begin
      core_rsp_valid <= 0; core_rsp_data <= '0; core_req_ready <= 0;
      cm_busy <= 0; cm_lat <= 0; cm_dly <= 0; cm_res <= '0;
    end else begin
      core_rsp_valid <= 0;
      core_req_ready <= (cyc % 4) != 3;
      if (cm_busy) begin
        if (cm_dly == 0) begin
          core_rsp_valid <= 1; core_rsp_data <= cm_res; cm_busy <= 0;
        end else cm_dly <= cm_dly - 1;
      end else if (core_req_valid && core_req_ready) begin
        cm_busy <= 1; cm_dly <= cm_lat; cm_lat <= (cm_lat + 1) % 3;
        cm_res <= core_req_fwd ? fenc(core_req_data) : fdec(core_req_data);
      end
    end
  end

  // monitor and reference model, every clock
  always @(negedge clk) begin
    if (!rst) begin
      if (core_req_valid) begin
        check(core_req_fwd == m_fwd, "R9", {127'd0, core_req_fwd}, {127'd0, m_fwd});
        check(!in_ready && !out_valid, "R12", {126'd0, in_ready, out_valid}, '0);
      end
      if (in_valid && in_ready) begin
        logic [BW-1:0] x, ci, co, r;
        x  = m_swap ? bswap(in_data) : in_data;
        ci = (m_xp == 2'd2) ? (x ^ m_chain) : x;
        co = m_fwd ? fenc(ci) : fdec(ci);
        r  = (m_xp == 2'd3) ? (co ^ m_chain) : co;
        if (m_xp[1] && m_vs == 2'd2) m_chain = co;
        if (m_xp[1] && m_vs == 2'd3) m_chain = x;
        exp_q.push_back(m_swap ? bswap(r) : r);
      end
      if (out_valid) begin
        if (exp_q.size() == 0) check(0, cur_tag, out_data, '0);
        else begin
          check(out_data == exp_q[0], cur_tag, out_data, exp_q[0]);
          if (out_ready) begin
            ct_log.push_back(out_data);
            void'(exp_q.pop_front());
          end
        end
      end
    end
  end

  task automatic start_job(input logic [1:0] xp, input logic [1:0] vs, input bit fwd,
                           input bit sw, input bit rng, input logic [BW-1:0] iv);
    cfg_xor_pos = xp; cfg_vec_src = vs; cfg_fwd = fwd; cfg_swap = sw;
    cfg_rng_en = rng; iv_in = iv; job_start = 1;
    @(posedge clk); #1;
    job_start = 0;
    m_xp = xp; m_vs = vs; m_fwd = fwd; m_swap = sw; m_chain = iv;
    @(negedge clk);
    check(chain_out == iv, "R2", chain_out, iv);
    @(posedge clk); #1;
  endtask

  task automatic send_block(input logic [BW-1:0] d);
    in_valid = 1; in_data = d;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic drain();
    do @(negedge clk); while (exp_q.size() != 0 || out_valid || core_req_valid);
    repeat (4) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic chain_chk(input string tag);
    @(negedge clk);
    check(chain_out == m_chain, tag, chain_out, m_chain);
    @(posedge clk); #1;
  endtask

  logic [BW-1:0] pt[4];
  logic [BW-1:0] cts[4];
  logic [BW-1:0] IV1 = 128'h00112233_44556677_8899aabb_ccddeeff;

  initial begin
    for (int i = 0; i < 4; i++) pt[i] = {4{32'h01020304 * (i + 3)}} ^ {96'd0, 32'(i)};
    repeat (3) @(posedge clk); #1;
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(in_ready == 1, "R1", {127'd0, in_ready}, 1);
    check(out_valid == 0 && core_req_valid == 0, "R1", {126'd0, out_valid, core_req_valid}, 0);
    check(chain_out == '0, "R1", chain_out, '0);
    @(posedge clk); #1;

    // R3 R8 ECB forward, vector source ignored
    cur_tag = "R3";
    start_job(2'd0, 2'd3, 1, 0, 0, IV1);
    for (int i = 0; i < 3; i++) send_block(pt[i]);
    drain();
    chain_chk("R8");
    check(chain_out == IV1, "R8", chain_out, IV1);

    // R3 XOR pos 1 bypass with vector source 2, inverse core
    start_job(2'd1, 2'd2, 0, 0, 0, ~IV1);
    for (int i = 0; i < 2; i++) send_block(pt[i]);
    drain();
    chain_chk("R8");

    // R4 R6 CBC encrypt with output stalls
    cur_tag = "R4";
    stall_en = 1;
    ct_log.delete();
    start_job(2'd2, 2'd2, 1, 0, 0, IV1);
    for (int i = 0; i < 4; i++) send_block(pt[i]);
    drain();
    chain_chk("R6");
    for (int i = 0; i < 4; i++) cts[i] = ct_log[i];
    chain_chk("R13");

    // R5 R7 CBC decrypt recovers the plaintext
    cur_tag = "R5";
    ct_log.delete();
    start_job(2'd3, 2'd3, 0, 0, 0, IV1);
    for (int i = 0; i < 4; i++) send_block(cts[i]);
    drain();
    chain_chk("R7");
    for (int i = 0; i < 4; i++) check(ct_log[i] == pt[i], "R5", ct_log[i], pt[i]);
    stall_en = 0;

    // R10 byte swap with CBC encrypt
    cur_tag = "R10";
    start_job(2'd2, 2'd2, 1, 1, 0, IV1);
    for (int i = 0; i < 3; i++) send_block(pt[i]);
    drain();
    chain_chk("R10");

    // R2 config pins changed mid-job have no effect
    cur_tag = "R2";
    start_job(2'd3, 2'd3, 0, 0, 0, ~IV1);
    cfg_xor_pos = 2'd2; cfg_vec_src = 2'd2; cfg_fwd = 1; cfg_swap = 1;
    for (int i = 0; i < 3; i++) send_block(pt[i]);
    drain();
    chain_chk("R2");

    // R11 generator enable blocks input
    start_job(2'd0, 2'd0, 1, 0, 1, IV1);
    in_valid = 1; in_data = pt[0];
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(in_ready == 0 && out_valid == 0, "R11", {126'd0, in_ready, out_valid}, 0);
    end
    @(posedge clk); #1;
    in_valid = 0;
    start_job(2'd0, 2'd0, 1, 0, 0, IV1);
    @(negedge clk);
    check(in_ready == 1, "R11", {127'd0, in_ready}, 1);
    @(posedge clk); #1;
    cur_tag = "R11";
    send_block(pt[1]);
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=finish", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule